// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches a bank of input-only pins, eight by default. Each pin passes through a synchronizer and then a debounce filter. The filter counts millisecond ticks, and those ticks come from a divider of the system clock whose ratio is set by a parameter. A pin's clean value changes only after the synchronized input has held the new level for that pin's own programmed number of ticks.

Once a pin's clean value equals its programmed polarity, the block records a pending event. This happens only while the pin is enabled, its interrupt is enabled and its one-shot arm bit is set. Recording the event clears the arm bit, so software must arm the pin again before the pin can report anything more. The single interrupt output is the OR of the pending bits that are still enabled. Software reaches the block through a simple register bus: a write strobe, one byte address, write data, and read data that follows the address in the same cycle. There is no streaming data path, so the bus has no back-pressure.

Top module: `dbi_bank`

## Requirements
- R1: The debounced value of pin n reads back at bit n of offset 0x00. It takes the synchronized input value only after that input has differed from it on L consecutive ticks, where L is the pin's debounce length.
- R2: If the synchronized input returns to the debounced value before L ticks have passed, the count restarts from zero and the debounced value stays unchanged.
- R3: The debounce length of pin n sits at offset 0x40 + 4*n. Only bits 11:0 are kept and the upper bits read 0. A value of 0 behaves like 1.
- R4: Offset 0x04 holds the enable bits. An enabled pin has its bit set to 1. A pin whose bit is 0 reads 0 at offset 0x00 and never sets a pending bit.
- R5: Offset 0x14 holds the polarity bits. A 1 means the pin is active when its debounced value is high, and a 0 means active when low. Only levels are detected.
- R6: A pin records an event only while its interrupt enable bit (offset 0x18) and its arm bit (offset 0x28) are both 1. The event sets its bit in the raw pending register (offset 0x1C) and clears its arm bit in the same cycle.
- R7: Offset 0x20 reads raw pending AND interrupt enable. irq_o is high exactly when any bit of that result is 1.
- R8: Writing a 1 to bit n of offset 0x24 clears pending bit n, and zero bits leave their pending bits alone. The offset reads 0. If an event and a clear hit the same bit in one cycle, the event wins.
- R9: Register bits above the pin count read 0, and unmapped offsets read 0.
- R10: One debounce tick lasts TICK_DIV clock cycles, with the first tick ending TICK_DIV cycles after reset.
- R11: After reset, every register reads 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Raw, asynchronous pin inputs |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, same cycle |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The bench targets four kinds of fault. One is a pulse shorter than the debounce window: a filter that kept its count across the bounce would let the pulse through. Another is re-arming a pin whose level is already active, which must fire at once; a design that waited for an edge would stay silent. A third is disabling a pin while its input is active: a design that still tracked it would raise a pending bit or show a stale 1 at the data offset. The last is a debounce length of zero, which must act as one tick, and a length write with junk in the upper bits, which must keep only twelve bits. A design that got this wrong would hang the pin or echo the junk.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  // Byte offsets of the register bus.
  localparam int unsigned OFS_LEVEL  = 32'h00;
  localparam int unsigned OFS_ENABLE = 32'h04;
  localparam int unsigned OFS_POLAR  = 32'h14;
  localparam int unsigned OFS_IRQEN  = 32'h18;
  localparam int unsigned OFS_RAW    = 32'h1C;
  localparam int unsigned OFS_MASKED = 32'h20;
  localparam int unsigned OFS_CLEAR  = 32'h24;
  localparam int unsigned OFS_ARM    = 32'h28;
  localparam int unsigned OFS_LEN0   = 32'h40;
  localparam int unsigned LEN_STRIDE = 32'h04;

  // Width of a counter that must reach limit-1.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/dbi_tick_gen.sv
module dbi_tick_gen #(
  parameter int unsigned TICK_DIV = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = dbi_pkg::cnt_width(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/dbi_pin_filter.sv
module dbi_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEN_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             level_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [LEN_W-1:0]       run_q;
  logic [LEN_W-1:0]       run_last;
  logic                   sampled;
  logic                   level_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign sampled  = sync_q[SYNC_STAGES-1];
  // A length of zero is treated as one tick.
  assign run_last = (len_i == '0) ? '0 : len_i - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (!enable_i) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (sampled == level_q) begin
      run_q   <= '0;
    end else if (tick_i) begin
      if (run_q >= run_last) begin
        level_q <= sampled;
        run_q   <= '0;
      end else begin
        run_q   <= run_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/dbi_irq_core.sv
module dbi_irq_core #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] enable_i,
  input  logic [NUM_PINS-1:0] polar_i,
  input  logic [NUM_PINS-1:0] irqen_i,
  input  logic                arm_wr_i,
  input  logic                clr_wr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] arm_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] raw_q;
  logic [NUM_PINS-1:0] arm_q;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] clr_mask;
  logic [NUM_PINS-1:0] arm_next;

  assign hit      = enable_i & irqen_i & arm_q & ~(level_i ^ polar_i);
  assign clr_mask = clr_wr_i ? wdata_i : '0;
  assign arm_next = arm_wr_i ? wdata_i : arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      arm_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_mask) | hit;   // event beats clear
      arm_q <= arm_next & ~hit;             // event consumes the arm bit
    end
  end

  assign raw_o = raw_q;
  assign arm_o = arm_q;
  assign irq_o = |(raw_q & irqen_i);
endmodule

// File: rtl/dbi_bank.sv
module dbi_bank #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned TICK_DIV    = 25000,
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o
);
  import dbi_pkg::*;

  localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_POLAR  = ADDR_W'(OFS_POLAR);
  localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(OFS_IRQEN);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFS_ARM);

  logic                tick;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] pol_q;
  logic [NUM_PINS-1:0] ie_q;
  logic [NUM_PINS-1:0] level_vec;
  logic [NUM_PINS-1:0] raw_vec;
  logic [NUM_PINS-1:0] arm_vec;
  logic [LEN_W-1:0]    len_q [NUM_PINS];
  logic [NUM_PINS-1:0] wdata_pins;
  logic [DATA_W-1:0]   len_rd;
  logic                unused_wdata;

  assign wdata_pins   = bus_wdata[NUM_PINS-1:0];
  assign unused_wdata = ^bus_wdata;

  dbi_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      ie_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_ENABLE) en_q  <= wdata_pins;
      if (bus_addr == A_POLAR)  pol_q <= wdata_pins;
      if (bus_addr == A_IRQEN)  ie_q  <= wdata_pins;
    end
  end

  generate
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      localparam logic [ADDR_W-1:0] A_LEN = ADDR_W'(OFS_LEN0 + LEN_STRIDE * n);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           len_q[n] <= '0;
        else if (bus_wr && bus_addr == A_LEN) len_q[n] <= bus_wdata[LEN_W-1:0];
      end

      dbi_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .LEN_W       (LEN_W)
      ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pins_i[n]),
        .enable_i (en_q[n]),
        .tick_i   (tick),
        .len_i    (len_q[n]),
        .level_o  (level_vec[n])
      );
    end
  endgenerate

  dbi_irq_core #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (level_vec),
    .enable_i (en_q),
    .polar_i  (pol_q),
    .irqen_i  (ie_q),
    .arm_wr_i (bus_wr && bus_addr == A_ARM),
    .clr_wr_i (bus_wr && bus_addr == A_CLEAR),
    .wdata_i  (wdata_pins),
    .raw_o    (raw_vec),
    .arm_o    (arm_vec),
    .irq_o    (irq_o)
  );

  always_comb begin
    len_rd = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (bus_addr == ADDR_W'(OFS_LEN0 + LEN_STRIDE * n)) len_rd = DATA_W'(len_q[n]);
    end
  end

  always_comb begin
    case (bus_addr)
      A_LEVEL:  bus_rdata = DATA_W'(level_vec);
      A_ENABLE: bus_rdata = DATA_W'(en_q);
      A_POLAR:  bus_rdata = DATA_W'(pol_q);
      A_IRQEN:  bus_rdata = DATA_W'(ie_q);
      A_RAW:    bus_rdata = DATA_W'(raw_vec);
      A_MASKED: bus_rdata = DATA_W'(raw_vec & ie_q);
      A_ARM:    bus_rdata = DATA_W'(arm_vec);
      default:  bus_rdata = len_rd;
    endcase
  end
endmodule

// File: rtl/dbi_bank_chk.sv
module dbi_bank_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic [NUM_PINS-1:0] level_vec,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] ie_q,
  input logic [NUM_PINS-1:0] raw_vec,
  input logic [NUM_PINS-1:0] arm_vec,
  input logic                irq_o
);
  // R1: an enabled pin's clean value moves only on the cycle after a tick
  a_r1_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|((level_vec ^ $past(level_vec)) & $past(en_q))) |-> $past(tick));

  // R4: a pin disabled in the previous cycle shows a clean value of 0
  a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (level_vec & ~$past(en_q)) == '0);

  // R6: a newly pending bit needs its arm bit set beforehand
  a_r6_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_vec & ~$past(raw_vec)) & ~$past(arm_vec)) == '0);

  // R6: a newly pending bit leaves its arm bit cleared
  a_r6_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_vec & ~$past(raw_vec)) & arm_vec) == '0);

  // R7: the interrupt line needs an enabled pending bit
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(raw_vec & ie_q)));
endmodule

bind dbi_bank dbi_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .level_vec (level_vec),
  .en_q      (en_q),
  .ie_q      (ie_q),
  .raw_vec   (raw_vec),
  .arm_vec   (arm_vec),
  .irq_o     (irq_o)
);

// File: tb/tb_dbi_bank.sv
module tb_dbi_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int DIV = 4;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbi_bank #(.NUM_PINS(NP), .TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  // Behavioural reference model
  int           m_tcnt;
  logic [NP-1:0] m_data, m_en, m_pol, m_ie, m_raw, m_arm;
  int           m_len [NP];
  int           m_run [NP];
  logic [NP-1:0] m_pipe [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tcnt = 0; m_data = '0; m_en = '0; m_pol = '0; m_ie = '0; m_raw = '0; m_arm = '0;
      for (int n = 0; n < NP; n++) begin m_len[n] = 0; m_run[n] = 0; end
      m_pipe = {};
      m_pipe.push_back('0); m_pipe.push_back('0);
    end else begin
      bit           tk;
      logic [NP-1:0] s, ev, nd, clr, narm;
      tk = (m_tcnt == DIV - 1);
      s  = m_pipe[0];
      ev = m_en & m_ie & m_arm & ~(m_data ^ m_pol);
      nd = m_data;
      for (int n = 0; n < NP; n++) begin
        int lim;
        lim = (m_len[n] == 0) ? 1 : m_len[n];
        if (!m_en[n]) begin nd[n] = 1'b0; m_run[n] = 0; end
        else if (s[n] == m_data[n]) m_run[n] = 0;
        else if (tk) begin
          if (m_run[n] + 1 >= lim) begin nd[n] = s[n]; m_run[n] = 0; end
          else m_run[n] = m_run[n] + 1;
        end
      end
      clr  = (bus_wr && bus_addr == 8'h24) ? bus_wdata[NP-1:0] : '0;
      narm = (bus_wr && bus_addr == 8'h28) ? bus_wdata[NP-1:0] : m_arm;
      m_raw  = (m_raw & ~clr) | ev;
      m_arm  = narm & ~ev;
      m_data = nd;
      if (bus_wr) begin
        if (bus_addr == 8'h04) m_en  = bus_wdata[NP-1:0];
        if (bus_addr == 8'h14) m_pol = bus_wdata[NP-1:0];
        if (bus_addr == 8'h18) m_ie  = bus_wdata[NP-1:0];
        for (int n = 0; n < NP; n++)
          if (bus_addr == 8'(8'h40 + 4*n)) m_len[n] = int'(bus_wdata[11:0]);
      end
      m_pipe.push_back(pins);
      void'(m_pipe.pop_front());
      m_tcnt = (m_tcnt == DIV - 1) ? 0 : m_tcnt + 1;
    end
  end

  // Per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        tests++;
        if (irq !== |(m_raw & m_ie)) begin
          fails++;
          $display("FAIL R7 irq per-cycle: got %0b expected %0b at %0t", irq, |(m_raw & m_ie), $time);
        end
        if (bus_addr == 8'h00) begin
          tests++;
          if (bus_rdata !== 32'(m_data)) begin
            fails++;
            $display("FAIL R1/R10 level per-cycle: got %h expected %h at %0t", bus_rdata, 32'(m_data), $time);
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #2;
    tests++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, bus_rdata, exp);
    end
    @(negedge clk); bus_addr = '0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); #2;
    tests++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq: got %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd(8'h00, 32'h0, "R11 level");
    rd(8'h04, 32'h0, "R11 enable");
    rd(8'h1C, 32'h0, "R11 raw");
    rd(8'h28, 32'h0, "R11 arm");
    rd(8'h40, 32'h0, "R11 len0");
    chk_irq(1'b0, "R11");

    // Pin0 active high, length 3; pin1 active low, length 0 (acts as 1)
    wr(8'h40, 32'd3);
    wr(8'h14, 32'h01);
    wr(8'h18, 32'h03);
    wr(8'h04, 32'h03);
    wr(8'h28, 32'h01);
    idle(20);
    rd(8'h1C, 32'h00, "R6 pin1 unarmed stays quiet");
    pins[0] = 1'b1;
    idle(40);
    rd(8'h00, 32'h01, "R1 level settles");
    rd(8'h1C, 32'h01, "R5 active-high event");
    rd(8'h28, 32'h00, "R6 arm consumed");
    rd(8'h20, 32'h01, "R7 masked");
    chk_irq(1'b1, "R7");

    // R2: short pulse on pin2 (length 5 ticks) is rejected
    wr(8'h48, 32'd5);
    wr(8'h04, 32'h07);
    pins[2] = 1'b1; idle(10); pins[2] = 1'b0;
    idle(40);
    rd(8'h00, 32'h01, "R2 bounce rejected");
    pins[2] = 1'b1;
    idle(60);
    rd(8'h00, 32'h05, "R2 long hold accepted");

    // R8: clear
    wr(8'h24, 32'h01);
    rd(8'h1C, 32'h00, "R8 cleared");
    rd(8'h24, 32'h00, "R8 clear reads zero");
    chk_irq(1'b0, "R8");

    // R5/R6: arming an already-active low pin fires at once
    wr(8'h28, 32'h02);
    idle(2);
    rd(8'h1C, 32'h02, "R5 active-low event");
    rd(8'h28, 32'h00, "R6 arm consumed pin1");

    // R7: disabling the interrupt enable masks but keeps raw
    wr(8'h18, 32'h01);
    rd(8'h20, 32'h00, "R7 masked off");
    rd(8'h1C, 32'h02, "R7 raw kept");
    chk_irq(1'b0, "R7 off");

    // R4: disabled pin neither reads nor reports
    wr(8'h04, 32'h06);
    idle(4);
    rd(8'h00, 32'h04, "R4 disabled reads zero");
    wr(8'h28, 32'h01);
    idle(30);
    rd(8'h1C, 32'h02, "R4 no status when disabled");
    rd(8'h28, 32'h01, "R4 arm untouched");
    wr(8'h04, 32'h07);
    idle(40);
    rd(8'h1C, 32'h03, "R6 event after re-enable");
    rd(8'h28, 32'h00, "R6 arm consumed again");

    // R3: length register width, zero acts as one
    wr(8'h44, 32'hFFFF_F123);
    rd(8'h44, 32'h0000_0123, "R3 twelve bits");
    wr(8'h04, 32'h17);
    idle(4);
    pins[4] = 1'b1;
    idle(12);
    rd(8'h00, 32'h15, "R3 zero length acts as one");

    // R10: two-tick length on pin5 needs more than a few cycles
    wr(8'h54, 32'd2);
    wr(8'h04, 32'h37);
    idle(4);
    pins[5] = 1'b1;
    idle(3);
    rd(8'h00, 32'h15, "R10 not yet");
    idle(20);
    rd(8'h00, 32'h35, "R10 after two ticks");

    // R9: unused bits and unmapped offsets
    rd(8'h30, 32'h0, "R9 unmapped");
    rd(8'h08, 32'h0, "R9 unmapped low");
    rd(8'h60, 32'h0, "R9 past last length");
    wr(8'h14, 32'hFFFF_FF01);
    rd(8'h14, 32'h0000_0001, "R9 upper bits zero");

    idle(10);
    summary();
    $finish;
  end
endmodule